// File: doc/BRIEF.md
# Paravirtual Device Register Window

This block is the byte-addressed I/O register window of a legacy paravirtual device. A host-side requester reaches it with single 8-, 16- or 32-bit reads and writes. It holds the feature words agreed between host and guest. It also holds one page-frame base per virtqueue, a queue selector, a queue-size readout, a device status byte and an interrupt status byte. The device core receives the guest feature word and the byte base address of the currently selected queue. It also receives a one-cycle doorbell pulse carrying a queue index and a one-cycle reset pulse. The core raises interrupt causes through a one-cycle set input, and the single level interrupt line follows bit 0 of the interrupt status byte.

A request is presented for one cycle on `req_valid_i`. A read answers on the following cycle with `rsp_valid_o` and `rsp_rdata_o`. A register responds only when the request address equals its offset exactly, and the access size truncates the data. Writing a zero status byte performs a soft reset of the guest-visible state. Reading the interrupt status byte acknowledges it.

Top module: `pvr_regwin`

## Requirements
- R1: A read at offset 0 returns `host_feat_i` with bits 24, 28 and 30 forced to 1.
- R2: A write at offset 4 stores the written value as the guest feature word on `guest_feat_o`. If bit 30 of the written value is 1, the parameter `GUEST_FALLBACK` (default 0) is stored instead.
- R3: A write at offset 8 stores the value as the page frame of the currently selected queue. A read at offset 8 returns that frame, and `sel_qbase_o` shows the selected queue's frame shifted left by 12.
- R4: A read at offset 12 returns the parameter `QUEUE_LEN` (default 256) as a 16-bit value, whichever queue is selected.
- R5: A write at offset 14 changes the queue selector only when the written value is below `NUM_Q` (default 16); otherwise the selector keeps its value. A read at offset 14 returns the selector.
- R6: A write at offset 16 raises `notify_o` for exactly one cycle, on the cycle after the write, with `notify_idx_o` equal to the low 16 bits of the written value.
- R7: A write at offset 18 keeps the low 8 bits as the status byte, and a read returns that byte. A resulting status of zero pulses `dev_reset_o` for one cycle, on the next cycle. The same write clears the guest feature word, every queue frame, the selector and the interrupt status byte.
- R8: A read at offset 19 returns the interrupt status byte and clears it. Bits on `isr_set_i` are ORed in every cycle, and a bit set in the same cycle as a clearing read or reset survives.
- R9: `irq_o` equals bit 0 of the interrupt status byte.
- R10: A read at any other offset, including 16 and 20 and above, returns all ones truncated to the access size. Writes to offsets 0, 12, 19 and unmapped offsets change nothing.
- R11: `req_size_i` encodes 0 = byte, 1 = halfword, 2 or 3 = word. Write data and read data are truncated to that many low bits, with upper read bits 0. The read response appears exactly one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | One-cycle access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset inside the window |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| host_feat_i | input | 32 | Feature word offered by the device core |
| isr_set_i | input | 8 | One-cycle interrupt cause set bits |
| irq_o | output | 1 | Level interrupt line |
| notify_o | output | 1 | Doorbell pulse |
| notify_idx_o | output | 16 | Queue index carried by the doorbell |
| dev_reset_o | output | 1 | Soft reset pulse toward the core |
| guest_feat_o | output | 32 | Accepted guest feature word |
| sel_qbase_o | output | PFN_W+12 | Byte base address of the selected queue |

## Verification
On every cycle, the assertions check four things. A rejected selector write leaves the selector unchanged. A clearing interrupt read with no new cause empties the status byte, and a rising interrupt line is always traced to a set of cause bit 0. Every doorbell, reset pulse or read response is traced to the request that caused it, and the reset pulse arrives with the cleared state. Only the bench's scenarios can show the exact read values. These cover the forced host feature bits, the per-queue frame storage across selector changes and size truncation, and the all-ones reads of unmapped offsets. They also show that a cause set in the same cycle as a clearing read survives it, and that writes to read-only offsets leave no trace.

// File: rtl/pvr_pkg.sv
package pvr_pkg;

  localparam int OFS_HOSTF  = 0;
  localparam int OFS_GUESTF = 4;
  localparam int OFS_PFN    = 8;
  localparam int OFS_QNUM   = 12;
  localparam int OFS_QSEL   = 14;
  localparam int OFS_NOTIFY = 16;
  localparam int OFS_STATUS = 18;
  localparam int OFS_ISR    = 19;

  localparam int FB_NOTIFY_EMPTY = 24;
  localparam int FB_INDIRECT     = 28;
  localparam int FB_BAD          = 30;

  localparam logic [31:0] HOST_FORCED =
    (32'd1 << FB_NOTIFY_EMPTY) | (32'd1 << FB_INDIRECT) | (32'd1 << FB_BAD);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic hostf;
    logic guestf;
    logic pfn;
    logic qnum;
    logic qsel;
    logic notify;
    logic status;
    logic isr;
  } reg_hit_t;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pvr_decode.sv
module pvr_decode
  import pvr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_hit_t          hit_o
);

  always_comb begin
    hit_o        = '0;
    hit_o.hostf  = (addr_i == ADDR_W'(OFS_HOSTF));
    hit_o.guestf = (addr_i == ADDR_W'(OFS_GUESTF));
    hit_o.pfn    = (addr_i == ADDR_W'(OFS_PFN));
    hit_o.qnum   = (addr_i == ADDR_W'(OFS_QNUM));
    hit_o.qsel   = (addr_i == ADDR_W'(OFS_QSEL));
    hit_o.notify = (addr_i == ADDR_W'(OFS_NOTIFY));
    hit_o.status = (addr_i == ADDR_W'(OFS_STATUS));
    hit_o.isr    = (addr_i == ADDR_W'(OFS_ISR));
  end

endmodule

// File: rtl/pvr_qbank.sv
module pvr_qbank #(
  parameter int NUM_Q = 16,
  parameter int PFN_W = 32,
  localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             sel_we_i,
  input  logic             pfn_we_i,
  input  logic [31:0]      wdata_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [PFN_W-1:0] pfn_o
);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_ok;
  logic [PFN_W-1:0] pfn_q [NUM_Q];
  logic [PFN_W-1:0] pfn_d [NUM_Q];
  logic [NUM_Q-1:0] q_we;

  assign sel_ok = (wdata_i < 32'(NUM_Q));

  always_comb begin
    sel_d = sel_q;
    if (clr_i)                  sel_d = '0;
    else if (sel_we_i && sel_ok) sel_d = wdata_i[SEL_W-1:0];
  end

  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_we
    assign q_we[gi] = pfn_we_i && (sel_q == SEL_W'(gi));
  end

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) begin
      pfn_d[i] = pfn_q[i];
      if (clr_i)        pfn_d[i] = '0;
      else if (q_we[i]) pfn_d[i] = wdata_i[PFN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_Q; i++) pfn_q[i] <= '0;
    end else begin
      sel_q <= sel_d;
      for (int i = 0; i < NUM_Q; i++) pfn_q[i] <= pfn_d[i];
    end
  end

  assign sel_o = sel_q;
  assign pfn_o = pfn_q[sel_q];

  // R5
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we_i && !clr_i && !sel_ok) |=> $stable(sel_o));

endmodule

// File: rtl/pvr_isr.sv
module pvr_isr #(
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ISR_W-1:0] set_i,
  input  logic             rd_clr_i,
  input  logic             clr_i,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o
);

  logic [ISR_W-1:0] isr_q, isr_d;

  always_comb begin
    isr_d = (rd_clr_i || clr_i) ? '0 : isr_q;
    isr_d = isr_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign isr_o = isr_q;
  assign irq_o = isr_q[0];

  // R8
  isr_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (set_i == '0)) |=> (isr_o == '0));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(set_i[0]));

endmodule

// File: rtl/pvr_regwin.sv
module pvr_regwin
  import pvr_pkg::*;
#(
  parameter int          ADDR_W         = 8,
  parameter int          NUM_Q          = 16,
  parameter int          PFN_W          = 32,
  parameter int          QUEUE_LEN      = 256,
  parameter logic [31:0] GUEST_FALLBACK = 32'h0,
  localparam int         PAGE_SHIFT     = 12,
  localparam int         BASE_W         = PFN_W + PAGE_SHIFT,
  localparam int         SEL_W          = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic [31:0]       host_feat_i,
  input  logic [7:0]        isr_set_i,
  output logic              irq_o,
  output logic              notify_o,
  output logic [15:0]       notify_idx_o,
  output logic              dev_reset_o,
  output logic [31:0]       guest_feat_o,
  output logic [BASE_W-1:0] sel_qbase_o
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  reg_hit_t    hit;
  logic        rd_en, wr_en, zero_status_wr;
  logic [31:0] wmask, wval, rmux;
  logic [SEL_W-1:0] sel;
  logic [PFN_W-1:0] pfn;
  logic [7:0]  isr;

  logic [31:0] guest_q, guest_d;
  logic [7:0]  status_q, status_d;
  logic        notify_q, notify_d;
  logic [15:0] nidx_q, nidx_d;
  logic        drst_q, drst_d;
  logic        rsp_q, rsp_d;
  logic [31:0] rdata_q, rdata_d;

  pvr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  assign rd_en          = req_valid_i && !req_write_i;
  assign wr_en          = req_valid_i && req_write_i;
  assign wmask          = size_mask(req_size_i);
  assign wval           = req_wdata_i & wmask;
  assign zero_status_wr = wr_en && hit.status && (wval[7:0] == 8'h00);

  pvr_qbank #(.NUM_Q(NUM_Q), .PFN_W(PFN_W)) u_qbank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (zero_status_wr),
    .sel_we_i (wr_en && hit.qsel),
    .pfn_we_i (wr_en && hit.pfn),
    .wdata_i  (wval),
    .sel_o    (sel),
    .pfn_o    (pfn)
  );

  pvr_isr #(.ISR_W(8)) u_isr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (isr_set_i),
    .rd_clr_i (rd_en && hit.isr),
    .clr_i    (zero_status_wr),
    .isr_o    (isr),
    .irq_o    (irq_o)
  );

  // next-state logic
  always_comb begin
    guest_d = guest_q;
    if (zero_status_wr)
      guest_d = '0;
    else if (wr_en && hit.guestf)
      guest_d = wval[FB_BAD] ? GUEST_FALLBACK : wval;

    status_d = status_q;
    if (wr_en && hit.status) status_d = wval[7:0];

    notify_d = wr_en && hit.notify;
    nidx_d   = notify_d ? wval[15:0] : nidx_q;
    drst_d   = zero_status_wr;
  end

  always_comb begin
    rmux = 32'hFFFF_FFFF;
    unique case (1'b1)
      hit.hostf:  rmux = host_feat_i | HOST_FORCED;
      hit.guestf: rmux = guest_q;
      hit.pfn:    rmux = 32'(pfn);
      hit.qnum:   rmux = 32'(16'(QUEUE_LEN));
      hit.qsel:   rmux = 32'(sel);
      hit.status: rmux = 32'(status_q);
      hit.isr:    rmux = 32'(isr);
      default:    rmux = 32'hFFFF_FFFF;
    endcase
    rsp_d   = rd_en;
    rdata_d = rd_en ? (rmux & wmask) : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      guest_q  <= '0;
      status_q <= '0;
      notify_q <= 1'b0;
      nidx_q   <= '0;
      drst_q   <= 1'b0;
      rsp_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      guest_q  <= guest_d;
      status_q <= status_d;
      notify_q <= notify_d;
      nidx_q   <= nidx_d;
      drst_q   <= drst_d;
      rsp_q    <= rsp_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rsp_valid_o  = rsp_q;
  assign rsp_rdata_o  = rdata_q;
  assign notify_o     = notify_q;
  assign notify_idx_o = nidx_q;
  assign dev_reset_o  = drst_q;
  assign guest_feat_o = guest_q;
  assign sel_qbase_o  = {pfn, {PAGE_SHIFT{1'b0}}};

  // R6
  notify_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    notify_o |-> $past(req_valid_i && req_write_i && hit.notify));

  // R7
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dev_reset_o |-> (guest_feat_o == '0 && sel_qbase_o == '0));

  // R2
  bad_feat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && hit.guestf && wval[FB_BAD]) |=> (guest_feat_o == GUEST_FALLBACK));

  // R11
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));

endmodule

// File: tb/pvr_regwin_tb.sv
module pvr_regwin_tb;

  localparam int NQ = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic [31:0] host_feat = 32'h0000_00A5;
  logic [7:0]  isr_set = '0;
  logic        rsp_valid, irq, notify, dev_reset;
  logic [31:0] rsp_rdata, guest_feat;
  logic [15:0] notify_idx;
  logic [43:0] sel_qbase;

  always #2 clk = ~clk;

  pvr_regwin u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .host_feat_i(host_feat), .isr_set_i(isr_set), .irq_o(irq),
    .notify_o(notify), .notify_idx_o(notify_idx), .dev_reset_o(dev_reset),
    .guest_feat_o(guest_feat), .sel_qbase_o(sel_qbase)
  );

  int vectors = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  // behavioural reference model
  longint unsigned m_guest, m_sel, m_status, m_isr, e_rdata, e_idx;
  longint unsigned m_pfn [NQ];
  bit e_rsp, e_notify, e_rst;
  string e_tag;

  always @(posedge clk) begin
    longint unsigned mask, wv, r;
    bit clr_isr;
    if (!rst_n) begin
      m_guest = 0; m_sel = 0; m_status = 0; m_isr = 0; e_rdata = 0; e_idx = 0;
      foreach (m_pfn[i]) m_pfn[i] = 0;
      e_rsp = 0; e_notify = 0; e_rst = 0; e_tag = "R11";
    end else begin
      mask = (req_size == 2'd0) ? 64'hFF : (req_size == 2'd1) ? 64'hFFFF : 64'hFFFF_FFFF;
      wv = req_wdata & mask;
      e_rsp = 0; e_notify = 0; e_rst = 0; clr_isr = 0;
      if (req_valid && req_write) begin
        case (req_addr)
          8'd4:  m_guest = wv[30] ? 0 : wv;
          8'd8:  m_pfn[m_sel] = wv;
          8'd14: if (wv < NQ) m_sel = wv;
          8'd16: begin e_notify = 1; e_idx = wv & 64'hFFFF; end
          8'd18: begin
            m_status = wv & 64'hFF;
            if (m_status == 0) begin
              m_guest = 0; m_sel = 0; clr_isr = 1; e_rst = 1;
              foreach (m_pfn[i]) m_pfn[i] = 0;
            end
          end
          default: ;
        endcase
      end else if (req_valid) begin
        case (req_addr)
          8'd0:  begin r = host_feat | 64'h5100_0000; e_tag = "R1"; end
          8'd4:  begin r = m_guest;      e_tag = "R2"; end
          8'd8:  begin r = m_pfn[m_sel]; e_tag = "R3"; end
          8'd12: begin r = 256;          e_tag = "R4"; end
          8'd14: begin r = m_sel;        e_tag = "R5"; end
          8'd18: begin r = m_status;     e_tag = "R7"; end
          8'd19: begin r = m_isr; clr_isr = 1; e_tag = "R8"; end
          default: begin r = 64'hFFFF_FFFF; e_tag = "R10"; end
        endcase
        if (req_size != 2'd2 && req_size != 2'd3) e_tag = {e_tag, "/R11"};
        e_rdata = r & mask;
        e_rsp = 1;
      end
      m_isr = (clr_isr ? 0 : m_isr) | isr_set;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rsp_valid == e_rsp, "R11 rsp_valid", rsp_valid, e_rsp);
      if (e_rsp) chk(rsp_rdata == e_rdata, e_tag, rsp_rdata, e_rdata);
      chk(irq == m_isr[0], "R9 irq", irq, m_isr[0]);
      chk(notify == e_notify, "R6 notify", notify, e_notify);
      chk(notify_idx == e_idx, "R6 notify_idx", notify_idx, e_idx);
      chk(dev_reset == e_rst, "R7 dev_reset", dev_reset, e_rst);
      chk(guest_feat == m_guest, "R2 guest_feat", guest_feat, m_guest);
      chk(sel_qbase == (m_pfn[m_sel] << 12), "R3 sel_qbase", sel_qbase, m_pfn[m_sel] << 12);
    end
  end

  task automatic acc(input bit w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [7:0] set = 8'h00);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    isr_set = set;
    @(negedge clk);
    req_valid = 0; req_write = 0; isr_set = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    acc(1'b1, a, sz, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz);
    acc(1'b0, a, sz, 32'h0);
  endtask

  task automatic set_isr(input logic [7:0] s);
    @(negedge clk); isr_set = s;
    @(negedge clk); isr_set = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    repeat (4) @(negedge clk);              // reset state
    // R1 host features, word and byte, exact offset
    rd(8'd0, 2'd2); rd(8'd0, 2'd0); rd(8'd3, 2'd0);
    host_feat = 32'h4000_0001; rd(8'd0, 2'd2);
    // R2 guest features and fallback
    wr(8'd4, 2'd2, 32'h0000_1234); rd(8'd4, 2'd2);
    wr(8'd4, 2'd2, 32'h4000_0007); rd(8'd4, 2'd2);
    wr(8'd4, 2'd1, 32'hFFFF_ABCD); rd(8'd4, 2'd2);
    // R3 and R5 queue frames and selector
    wr(8'd14, 2'd1, 32'd3); wr(8'd8, 2'd2, 32'h0001_2345); rd(8'd8, 2'd2);
    wr(8'd14, 2'd1, 32'd5); wr(8'd8, 2'd2, 32'h0000_0777); rd(8'd8, 2'd2);
    wr(8'd14, 2'd1, 32'd16); rd(8'd14, 2'd1);
    wr(8'd14, 2'd2, 32'h0000_FFFF); rd(8'd14, 2'd2);
    wr(8'd14, 2'd1, 32'd15); rd(8'd14, 2'd1);
    wr(8'd14, 2'd0, 32'h0000_0103); rd(8'd8, 2'd2); rd(8'd8, 2'd0);
    // R4 queue size
    rd(8'd12, 2'd2); rd(8'd12, 2'd0);
    // R6 doorbell
    wr(8'd16, 2'd1, 32'd7); wr(8'd16, 2'd2, 32'h0001_0003);
    // R8 and R9 interrupt status
    set_isr(8'h03); rd(8'd19, 2'd0); rd(8'd19, 2'd0);
    set_isr(8'h02); set_isr(8'h01);
    acc(1'b0, 8'd19, 2'd0, 32'h0, 8'h01); rd(8'd19, 2'd0);
    // R10 unmapped reads and ignored writes
    rd(8'd16, 2'd1); rd(8'd20, 2'd2); rd(8'd31, 2'd1); rd(8'd2, 2'd2);
    wr(8'd0, 2'd2, 32'h0); wr(8'd12, 2'd2, 32'h0); wr(8'd19, 2'd0, 32'h0);
    wr(8'd40, 2'd2, 32'hFFFF_FFFF);
    rd(8'd0, 2'd2); rd(8'd12, 2'd1); rd(8'd4, 2'd2);
    // R7 status and soft reset
    wr(8'd18, 2'd0, 32'h0F); rd(8'd18, 2'd0);
    set_isr(8'h05);
    wr(8'd18, 2'd2, 32'h0000_0100);
    rd(8'd18, 2'd2); rd(8'd4, 2'd2); rd(8'd14, 2'd1); rd(8'd19, 2'd0);
    wr(8'd14, 2'd1, 32'd3); rd(8'd8, 2'd2);
    wr(8'd18, 2'd0, 32'h00);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule